// File: doc/BRIEF.md
# Toroidal Serial Life Update Engine

This block computes the next Game of Life generation for a square cell array whose edges wrap, so the array behaves as a torus. An external step-time counter drives it. The counter's top bit opens an update window. Inside the window the engine runs one stage per row. Each stage has two halves. In the capture half, the engine walks a row-select output through every row and latches the three rows it needs from the parallel row bus. In the rotate half, it circulates those three rows and emits one new cell per clock on a serial line.

The serial bits fill a shadow chain. The visible matrix keeps showing the old generation for the whole window. It takes the complete new generation in a single step once the window closes. Cells use 1 for dead and 0 for alive. The surrounding system feeds the row bus from the visible matrix, using the row select.

The block is a four-state machine. IDLE means outside the window. CAPTURE means the window is open with the phase bit at 0. ROTATE means the window is open with the phase bit at 1. PUBLISH is the single cycle after the window closes. The transitions are:
- IDLE or PUBLISH goes to CAPTURE or ROTATE when the window bit is set, and otherwise to IDLE.
- CAPTURE or ROTATE follows the phase bit while the window bit stays set, and goes to PUBLISH when it clears.

Top module: `life_torus_engine`

## Requirements
- R1: In reset, the visible matrix equals the INIT_PATTERN parameter and the serial clock enable is 0.
- R2: The step-time field is decoded as follows. Bit 7 is the window. Bits 6..4 are the stage. Bit 3 is the phase. Bits 2..0 are the index. The serial clock enable is 1 exactly in cycles where bit 7 and bit 3 are both 1.
- R3: The row select output always equals bits 2..0 of the step time.
- R4: In stage s the current row is 7-s, and the neighbour rows are 6-s and 8-s, taken modulo 8. Stage 0 therefore uses rows 6, 7 and 0. Each row is latched when its index is on the bus during the capture phase.
- R5: The serial output carries the new generation in this order: row 7 first, then row 6 and onward to row 0. Within a row, column 7 comes first and column 0 last. Each cycle of the rotate phase carries one bit, with 1 meaning dead and 0 meaning alive.
- R6: A dead cell becomes alive with exactly 3 live neighbours among its 8. A live cell stays alive with 2 or 3 live neighbours. Every other cell is dead in the next generation.
- R7: Column neighbours wrap. Column 7 neighbours column 0.
- R8: Bit (row*8+col) of the visible matrix holds cell (row, col). The visible matrix does not change while bit 7 is 1. It takes the complete new generation at the clock edge that closes the first cycle with bit 7 at 0 after a window.
- R9: Row bus values outside capture cycles do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_time | input | 8 | Step-time counter: window, stage, phase, index |
| row_bus | input | 8 | Parallel data of the selected row, bit c = column c |
| row_sel | output | 3 | Row whose data is expected on row_bus |
| ser_data | output | 1 | New cell value, 1 = dead |
| ser_clk_en | output | 1 | Qualifies ser_data and shifts the shadow chain |
| vis_matrix | output | 64 | Visible generation, bit r*8+c = cell (r,c) |

## Verification
The assertions assume the following about the step-time input. It advances once per clock through every value, so each window presents all eight stages, each with a full capture half followed by a full rotate half. They also assume the row bus shows the visible row named by row_sel during capture. The stimulus drives the counter as a plain wrapping count from 0 to 255 and fills the row bus from the bench's own copy of the current generation. It drives unrelated random values on the bus in all other cycles. The seed pattern holds a glider and a blinker that straddles the column 7/0 edge, so both vertical and horizontal wrap occur within the generations run.

// File: rtl/life_pkg.sv
package life_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_ROTATE  = 2'd2,
        MODE_PUBLISH = 2'd3
    } mode_e;
endpackage

// File: rtl/life_row_rotor.sv
module life_row_rotor #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         rot,
    input  logic [N-1:0] din,
    output logic [2:0]   taps
);
    logic [N-1:0] q;
    logic [N-1:0] din_pre;

    // pre-rotation: slot i takes column (i+N-2) mod N, so slots 0..2
    // show columns N-2, N-1, 0 for the first updated cell
    for (genvar i = 0; i < N; i++) begin : g_pre
        assign din_pre[i] = din[(i + N - 2) % N];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '1;
        else if (load)
            q <= din_pre;
        else if (rot)
            q <= {q[N-2:0], q[N-1]};
    end

    assign taps = q[2:0];
endmodule

// File: rtl/life_rule.sv
module life_rule (
    input  logic [8:0] window,
    output logic       next_dead
);
    logic [8:0] alive;
    logic [3:0] count;

    assign alive = ~window;

    always_comb begin
        count = '0;
        for (int i = 0; i < 9; i++) begin
            if (i != 4)
                count = count + {3'b000, alive[i]};
        end
    end

    assign next_dead = !((count == 4'd3) || ((count == 4'd2) && alive[4]));
endmodule

// File: rtl/life_shadow_matrix.sv
module life_shadow_matrix #(
    parameter int               CELLS = 64,
    parameter logic [CELLS-1:0] INIT  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             publish,
    output logic [CELLS-1:0] shadow,
    output logic [CELLS-1:0] visible
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow  <= '1;
            visible <= INIT;
        end else begin
            if (shift_en)
                shadow <= {shadow[CELLS-2:0], shift_bit};
            if (publish)
                visible <= shadow;
        end
    end
endmodule

// File: rtl/life_torus_engine.sv
module life_torus_engine #(
    parameter int               N            = 8,
    parameter logic [N*N-1:0]   INIT_PATTERN = '1,
    localparam int              IDX_W        = $clog2(N),
    localparam int              TW           = 2 * IDX_W + 2,
    localparam int              CELLS        = N * N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        step_time,
    input  logic [N-1:0]         row_bus,
    output logic [IDX_W-1:0]     row_sel,
    output logic                 ser_data,
    output logic                 ser_clk_en,
    output logic [CELLS-1:0]     vis_matrix
);
    import life_pkg::*;

    logic             active, phase;
    logic [IDX_W-1:0] idx, stage, cur_row;
    mode_e            mode_q, mode_d;
    logic             load_en, rot_en, publish;
    logic [IDX_W-1:0] tgt_row [3];
    logic [8:0]       taps_flat;
    logic [CELLS-1:0] shadow_bits;

    assign active  = step_time[TW-1];
    assign stage   = step_time[2*IDX_W:IDX_W+1];
    assign phase   = step_time[IDX_W];
    assign idx     = step_time[IDX_W-1:0];
    assign cur_row = IDX_W'(N - 1) - stage;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_IDLE;
        else
            mode_q <= mode_d;
    end

    // transitions
    always_comb begin
        mode_d = MODE_IDLE;
        unique case (mode_q)
            MODE_IDLE, MODE_PUBLISH:
                mode_d = active ? (phase ? MODE_ROTATE : MODE_CAPTURE) : MODE_IDLE;
            MODE_CAPTURE, MODE_ROTATE:
                mode_d = active ? (phase ? MODE_ROTATE : MODE_CAPTURE) : MODE_PUBLISH;
            default:
                mode_d = MODE_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        load_en    = (mode_d == MODE_CAPTURE);
        rot_en     = (mode_d == MODE_ROTATE);
        publish    = (mode_d == MODE_PUBLISH);
        ser_clk_en = rot_en;
    end

    assign row_sel = idx;

    // rotor 0: previous row, 1: current row, 2: next row (torus wrap)
    assign tgt_row[0] = cur_row - IDX_W'(1);
    assign tgt_row[1] = cur_row;
    assign tgt_row[2] = cur_row + IDX_W'(1);

    for (genvar k = 0; k < 3; k++) begin : g_rotor
        logic [2:0] t;
        life_row_rotor #(.N(N)) rotor_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_en && (idx == tgt_row[k])),
            .rot   (rot_en),
            .din   (row_bus),
            .taps  (t)
        );
        assign taps_flat[3*k +: 3] = t;
    end

    life_rule rule_i (
        .window    (taps_flat),
        .next_dead (ser_data)
    );

    life_shadow_matrix #(.CELLS(CELLS), .INIT(INIT_PATTERN)) shadow_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (ser_clk_en),
        .shift_bit (ser_data),
        .publish   (publish),
        .shadow    (shadow_bits),
        .visible   (vis_matrix)
    );
endmodule

// File: rtl/life_torus_engine_chk.sv
module life_torus_engine_chk #(
    parameter int N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_bit,
    input logic             phase_bit,
    input logic             ser_clk_en,
    input logic [N*N-1:0]   vis_matrix,
    input logic [N*N-1:0]   shadow,
    input logic [8:0]       taps_flat,
    input life_pkg::mode_e  mode_d
);
    // R2: serial clock only inside the window and in the rotate phase
    p_clk_en_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_en |-> (win_bit && phase_bit));

    // R8: visible matrix frozen across window cycles
    p_vis_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_bit |=> $stable(vis_matrix));

    // R8: publish cycle copies the completed shadow chain
    p_publish_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_d == life_pkg::MODE_PUBLISH) |=> (vis_matrix == $past(shadow)));

    // R5: shadow chain moves only on qualified serial clocks
    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk_en |=> $stable(shadow));

    // R9: rotors neither load nor rotate outside the window
    p_rotor_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_bit |=> $stable(taps_flat));
endmodule

bind life_torus_engine life_torus_engine_chk #(.N(N)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_bit    (step_time[TW-1]),
    .phase_bit  (step_time[IDX_W]),
    .ser_clk_en (ser_clk_en),
    .vis_matrix (vis_matrix),
    .shadow     (shadow_bits),
    .taps_flat  (taps_flat),
    .mode_d     (mode_d)
);

// File: tb/life_torus_engine_tb_top.sv
`timescale 1ns/1ps
module life_torus_engine_tb_top;
    localparam int NGEN = 12;
    localparam logic [63:0] ALIVE =
        (64'd1 << 3) | (64'd1 << 12) | (64'd1 << 18) | (64'd1 << 19) |
        (64'd1 << 20) | (64'd1 << 47) | (64'd1 << 40) | (64'd1 << 41);
    localparam logic [63:0] INIT = ~ALIVE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  step_time = '0;
    logic [7:0]  row_bus;
    logic [2:0]  row_sel;
    logic        ser_data, ser_clk_en;
    logic [63:0] vis_matrix;

    logic [63:0] model = INIT;
    logic [63:0] pend  = INIT;
    logic [7:0]  junk  = '0;
    logic        expq[$];
    int          n_checks = 0;
    int          n_fails  = 0;

    always #10 clk = ~clk;

    life_torus_engine #(.N(8), .INIT_PATTERN(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_time(step_time), .row_bus(row_bus),
        .row_sel(row_sel), .ser_data(ser_data), .ser_clk_en(ser_clk_en),
        .vis_matrix(vis_matrix)
    );

    // bus: model row in capture cycles, random junk otherwise (R9)
    always_comb begin
        if (step_time[7] && !step_time[3])
            row_bus = model[{row_sel, 3'b000} +: 8];
        else
            row_bus = junk;
    end

    function automatic logic [63:0] life_next(input logic [63:0] g);
        logic [63:0] r;
        r = '1;
        for (int y = 0; y < 8; y++) begin
            for (int x = 0; x < 8; x++) begin
                int n = 0;
                for (int dy = -1; dy <= 1; dy++)
                    for (int dx = -1; dx <= 1; dx++)
                        if (dy != 0 || dx != 0)
                            if (!g[((y + dy + 8) % 8) * 8 + ((x + dx + 8) % 8)]) n++;
                if (n == 3 || (n == 2 && !g[y*8 + x])) r[y*8 + x] = 1'b0;
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [7:0] t);
        @(posedge clk);
        #1;
        step_time = t;
        junk = 8'($urandom);
    endtask

    // scoreboard monitor: R5 order, R6 rule, R7 column wrap, R4 row choice
    always @(negedge clk) begin
        if (rst_n && ser_clk_en) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5 unexpected serial bit", 64'(ser_data), 64'd0);
            end else begin
                logic e;
                e = expq.pop_front();
                check(ser_data === e, "R5 R6 R7 R4 serial cell", 64'(ser_data), 64'(e));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(vis_matrix === INIT, "R1 reset matrix", vis_matrix, INIT);
        check(ser_clk_en === 1'b0, "R1 reset clk enable", 64'(ser_clk_en), 64'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        for (int g = 0; g < NGEN; g++) begin
            for (int t = 0; t < 256; t++) begin
                if (t == 128) begin
                    pend = life_next(model);
                    for (int s = 0; s < 8; s++)
                        for (int k = 0; k < 8; k++)
                            expq.push_back(pend[(7 - s) * 8 + (7 - k)]);
                end
                tick(8'(t));
                @(negedge clk);
                check(ser_clk_en === (step_time[7] & step_time[3]), "R2 clock enable",
                      64'(ser_clk_en), 64'(step_time[7] & step_time[3]));
                if (t % 7 == 0)
                    check(row_sel === step_time[2:0], "R3 row select",
                          64'(row_sel), 64'(step_time[2:0]));
                if (t == 1 && g > 0) begin
                    check(vis_matrix === pend, "R8 publish", vis_matrix, pend);
                    model = pend;
                end
                if (t == 200 || t == 255)
                    check(vis_matrix === model, "R8 hold in window", vis_matrix, model);
            end
        end
        tick(8'd0);
        tick(8'd1);
        @(negedge clk);
        check(vis_matrix === pend, "R8 final publish", vis_matrix, pend);
        check(expq.size() == 0, "R5 all bits emitted", 64'(expq.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule